// File: doc/BRIEF.md
# Drive Strength Resolution Unit

This combinational block merges two drivers that share one net and returns the resolved signal, which carries both a logic value and a strength. Each value side has eight strength levels. The levels form one scale. It runs from the strongest 0, down through high impedance, and up to the strongest 1. A driver either sits at one point on that scale (unambiguous) or covers a range that reaches into both value sides (ambiguous).

A driver is described by four fields:
- a 3-bit strength for its 0 component;
- a 3-bit strength for its 1 component;
- a flag that says the 0 component is present;
- a flag that says the 1 component is present.

A net-type select picks how an equal-strength conflict between two unambiguous drivers ends: plain wire, wired-AND or wired-OR. The block returns the resolved driver in the same four-field form, plus a 4-state logic code.

To resolve more than two drivers, feed the output of one unit into a second unit.

Top module: `drive_strength_resolver`

## Requirements
- R1: Strength codes are 3 bits. 7 is supply, then 6 strong, 5 pull, 4 large, 3 weak, 2 medium, 1 small, and 0 is high impedance. A driver whose presence flags are exactly one of `Has0`/`Has1` is unambiguous. The strength field of an absent component is ignored on input. On output, an absent component's field is 0 and at least one flag is set.
- R2: A driver with no flag set, or whose present components all have strength 0, is high impedance. It is written as both flags set and both strengths 0. This form on the output gives logic code z.
- R3: Two unambiguous drivers with opposite values and different strengths resolve to the stronger driver, unchanged.
- R4: Two unambiguous drivers with the same value resolve to that value, at the larger of the two strengths.
- R5: Two unambiguous drivers with opposite values and equal strength s give both flags set with both strengths s when the net select is 00 (wire) or 11 (treated as wire).
- R6: In the R5 situation, net select 01 (wired-AND) gives value 0 only, at strength s.
- R7: In the R5 situation, net select 10 (wired-OR) gives value 1 only, at strength s.
- R8: When an ambiguous driver meets an unambiguous driver of value v and strength u, the ambiguous driver's component on the side opposite v survives if its strength is above u.
- R9: In the R8 situation, an opposite-side component with strength at or below u is dropped: its flag is cleared and its field is 0.
- R10: In the R8 situation, the result always has side v present. Its strength is the larger of u and the ambiguous driver's side-v strength.
- R11: Two ambiguous drivers resolve to both flags set, each side at the larger of the two strengths on that side, whatever the net select.
- R12: The logic code is 00 for zero, 01 for one, 10 for z and 11 for x.
  - It is z when both result strengths are 0.
  - It is x when both flags are set and both strengths are above 0.
  - Otherwise it is the value of the side whose strength is above 0.
- R13: A high-impedance driver has no effect: the result equals the other driver in its R1/R2 form.
- R14: Swapping the two driver inputs gives an identical output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| drvAHas0 | input | 1 | Driver A has a 0 component |
| drvAHas1 | input | 1 | Driver A has a 1 component |
| drvAStr0 | input | 3 | Driver A strength on the 0 side |
| drvAStr1 | input | 3 | Driver A strength on the 1 side |
| drvBHas0 | input | 1 | Driver B has a 0 component |
| drvBHas1 | input | 1 | Driver B has a 1 component |
| drvBStr0 | input | 3 | Driver B strength on the 0 side |
| drvBStr1 | input | 3 | Driver B strength on the 1 side |
| netSel | input | 2 | Net type: 00 wire, 01 wired-AND, 10 wired-OR, 11 wire |
| resHas0 | output | 1 | Result has a 0 component |
| resHas1 | output | 1 | Result has a 1 component |
| resStr0 | output | 3 | Result strength on the 0 side |
| resStr1 | output | 3 | Result strength on the 1 side |
| resLogic | output | 2 | Logic code: 00 zero, 01 one, 10 z, 11 x |

## Verification
The assertions take for granted that every input bit is a known 0 or 1. They stay silent while any input is unknown, and the stimulus therefore only ever drives fully known codes. They also assume that the high-impedance form and the unambiguous form are judged after the absent fields are cleared. To probe that clearing, the stimulus deliberately places nonzero values in absent strength fields and uses single-flag strength-0 drivers. Every ordered pair of unambiguous drivers is applied under all four net codes, which also covers both input orders. Ambiguous drivers are swept against unambiguous ones in both input positions, and against each other over a reduced set of strengths.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int STR_W = 3;

  typedef logic [STR_W-1:0] strength_t;

  localparam strength_t STR_HIGHZ = '0;

  // index 0 = logic-0 side, index 1 = logic-1 side
  typedef struct packed {
    logic [1:0] has;
    strength_t [1:0] str;
  } drive_t;

  localparam drive_t DRIVE_Z = drive_t'({2'b11, {(2*STR_W){1'b0}}});

  typedef enum logic [1:0] {
    NET_WIRE = 2'b00,
    NET_WAND = 2'b01,
    NET_WOR  = 2'b10,
    NET_RSVD = 2'b11
  } net_e;

  typedef enum logic [1:0] {
    LV_ZERO = 2'b00,
    LV_ONE  = 2'b01,
    LV_Z    = 2'b10,
    LV_X    = 2'b11
  } lv_e;

  typedef enum logic [1:0] {
    TIE_X    = 2'b00,
    TIE_ZERO = 2'b01,
    TIE_ONE  = 2'b10
  } tie_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [1:0] killA;
    logic [1:0] killB;
    logic       tie;
    tie_e       tieMode;
    strength_t  tieStr;
  } dsr_strobe_t;

  function automatic strength_t unambLevel(drive_t d);
    return d.has[1] ? d.str[1] : d.str[0];
  endfunction
endpackage

// File: rtl/dsr_norm.sv
module dsr_norm import dsr_pkg::*; (
  input  logic [1:0]      hasIn,
  input  strength_t [1:0] strIn,
  output drive_t          drvOut
);
  drive_t cleared;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      cleared.has[c] = hasIn[c];
      cleared.str[c] = hasIn[c] ? strIn[c] : STR_HIGHZ;
    end
    // nothing above highz left: canonical high impedance
    if (cleared.str == '0) drvOut = DRIVE_Z;
    else                   drvOut = cleared;
  end
endmodule

// File: rtl/dsr_ctrl.sv
module dsr_ctrl import dsr_pkg::*; (
  input  drive_t      drvA,
  input  drive_t      drvB,
  input  logic [1:0]  netSel,
  output dsr_strobe_t strobe
);
  logic aUnamb, bUnamb;
  logic [1:0] killA, killB;
  logic tie;
  tie_e tieMode;

  assign aUnamb = ^drvA.has;
  assign bUnamb = ^drvB.has;

  // a component dies when the other driver is a single point of the
  // opposite value that is at least as strong
  for (genvar c = 0; c < 2; c++) begin : g_side
    localparam int OPP = 1 - c;
    assign killA[c] = drvA.has[c] & bUnamb & drvB.has[OPP] &
                      (drvB.str[OPP] >= drvA.str[c]);
    assign killB[c] = drvB.has[c] & aUnamb & drvA.has[OPP] &
                      (drvA.str[OPP] >= drvB.str[c]);
  end

  assign tie = aUnamb & bUnamb & (drvA.has != drvB.has) &
               (unambLevel(drvA) == unambLevel(drvB));

  always_comb begin
    case (net_e'(netSel))
      NET_WAND: tieMode = TIE_ZERO;
      NET_WOR:  tieMode = TIE_ONE;
      default:  tieMode = TIE_X;
    endcase
  end

  assign strobe = '{killA: killA, killB: killB, tie: tie,
                    tieMode: tieMode, tieStr: unambLevel(drvA)};

  always_comb begin
    if (!$isunknown({drvA, drvB}) && tie)
      AST_TIE_KILLS_BOTH: assert (killA == drvA.has && killB == drvB.has); // R5
  end
endmodule

// File: rtl/dsr_datapath.sv
module dsr_datapath import dsr_pkg::*; (
  input  drive_t      drvA,
  input  drive_t      drvB,
  input  dsr_strobe_t strobe,
  output drive_t      res,
  output lv_e         logicOut
);
  drive_t merged;

  for (genvar c = 0; c < 2; c++) begin : g_merge
    logic keepA, keepB;
    strength_t strA, strB;
    assign keepA = drvA.has[c] & ~strobe.killA[c];
    assign keepB = drvB.has[c] & ~strobe.killB[c];
    assign strA  = keepA ? drvA.str[c] : STR_HIGHZ;
    assign strB  = keepB ? drvB.str[c] : STR_HIGHZ;
    assign merged.has[c] = keepA | keepB;
    assign merged.str[c] = (strA > strB) ? strA : strB;
  end

  always_comb begin
    res = merged;
    if (strobe.tie) begin
      case (strobe.tieMode)
        TIE_ZERO: res = drive_t'({2'b01, STR_HIGHZ, strobe.tieStr});
        TIE_ONE:  res = drive_t'({2'b10, strobe.tieStr, STR_HIGHZ});
        default:  res = drive_t'({2'b11, strobe.tieStr, strobe.tieStr});
      endcase
    end
  end

  always_comb begin
    if (res.str == '0)                                   logicOut = LV_Z;
    else if (res.has == 2'b11 && res.str[0] != STR_HIGHZ
             && res.str[1] != STR_HIGHZ)                 logicOut = LV_X;
    else if (res.str[1] != STR_HIGHZ)                    logicOut = LV_ONE;
    else                                                 logicOut = LV_ZERO;
  end

  always_comb begin
    if (!$isunknown({drvA, drvB, strobe})) begin
      AST_RESULT_NONEMPTY: assert (res.has != 2'b00); // R1
      AST_ABSENT_FIELD_ZERO: assert ((res.has[0] || res.str[0] == '0) &&
                                     (res.has[1] || res.str[1] == '0)); // R1
    end
  end
endmodule

// File: rtl/drive_strength_resolver.sv
module drive_strength_resolver import dsr_pkg::*; (
  input  logic             drvAHas0,
  input  logic             drvAHas1,
  input  logic [STR_W-1:0] drvAStr0,
  input  logic [STR_W-1:0] drvAStr1,
  input  logic             drvBHas0,
  input  logic             drvBHas1,
  input  logic [STR_W-1:0] drvBStr0,
  input  logic [STR_W-1:0] drvBStr1,
  input  logic [1:0]       netSel,
  output logic             resHas0,
  output logic             resHas1,
  output logic [STR_W-1:0] resStr0,
  output logic [STR_W-1:0] resStr1,
  output logic [1:0]       resLogic
);
  localparam int N_DRV = 2;

  logic [1:0]      hasIn   [N_DRV];
  strength_t [1:0] strIn   [N_DRV];
  drive_t          normDrv [N_DRV];
  dsr_strobe_t     strobe;
  drive_t          res;
  lv_e             logicOut;

  assign hasIn[0] = {drvAHas1, drvAHas0};
  assign strIn[0] = {drvAStr1, drvAStr0};
  assign hasIn[1] = {drvBHas1, drvBHas0};
  assign strIn[1] = {drvBStr1, drvBStr0};

  for (genvar d = 0; d < N_DRV; d++) begin : g_norm
    dsr_norm uNorm (.hasIn(hasIn[d]), .strIn(strIn[d]), .drvOut(normDrv[d]));
  end

  dsr_ctrl uCtrl (
    .drvA(normDrv[0]), .drvB(normDrv[1]), .netSel(netSel), .strobe(strobe)
  );

  dsr_datapath uData (
    .drvA(normDrv[0]), .drvB(normDrv[1]), .strobe(strobe),
    .res(res), .logicOut(logicOut)
  );

  assign resHas0  = res.has[0];
  assign resHas1  = res.has[1];
  assign resStr0  = res.str[0];
  assign resStr1  = res.str[1];
  assign resLogic = logicOut;

  always_comb begin
    if (!$isunknown({hasIn[0], strIn[0], hasIn[1], strIn[1], netSel})) begin
      if ((^normDrv[0].has) && (^normDrv[1].has) &&
          normDrv[0].has != normDrv[1].has &&
          unambLevel(normDrv[0]) != unambLevel(normDrv[1]))
        AST_STRONGER_WINS: assert (res == ((unambLevel(normDrv[0]) > unambLevel(normDrv[1]))
                                           ? normDrv[0] : normDrv[1])); // R3
      if (normDrv[1] == DRIVE_Z)
        AST_HIZ_TRANSPARENT: assert (res == normDrv[0]); // R13
      if (normDrv[0].has == 2'b11 && normDrv[1].has == 2'b11)
        AST_AMB_MERGE_MAX: assert (res.has == 2'b11 &&
          res.str[0] == ((normDrv[0].str[0] > normDrv[1].str[0]) ? normDrv[0].str[0] : normDrv[1].str[0]) &&
          res.str[1] == ((normDrv[0].str[1] > normDrv[1].str[1]) ? normDrv[0].str[1] : normDrv[1].str[1])); // R11
    end
  end
endmodule

// File: tb/tb_drive_strength_resolver.sv
module tb_drive_strength_resolver;
  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic       drvAHas0 = 0, drvAHas1 = 0, drvBHas0 = 0, drvBHas1 = 0;
  logic [2:0] drvAStr0 = 0, drvAStr1 = 0, drvBStr0 = 0, drvBStr1 = 0;
  logic [1:0] netSel = 0;
  logic       resHas0, resHas1;
  logic [2:0] resStr0, resStr1;
  logic [1:0] resLogic;

  drive_strength_resolver dut (
    .drvAHas0(drvAHas0), .drvAHas1(drvAHas1), .drvAStr0(drvAStr0), .drvAStr1(drvAStr1),
    .drvBHas0(drvBHas0), .drvBHas1(drvBHas1), .drvBStr0(drvBStr0), .drvBStr1(drvBStr1),
    .netSel(netSel), .resHas0(resHas0), .resHas1(resHas1),
    .resStr0(resStr0), .resStr1(resStr1), .resLogic(resLogic)
  );

  typedef struct {
    logic [1:0] h;
    int         s0;
    int         s1;
    logic [1:0] lv;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic int imax(int x, int y);
    return (x > y) ? x : y;
  endfunction

  // ambiguous (m0,m1) against a single point of value v, strength u
  function automatic void mixAmb(input int m0, input int m1, input logic v, input int u,
                                 output logic [1:0] rH, output int r0, output int r1);
    if (v) begin
      r1 = imax(m1, u); rH[1] = 1'b1;
      if (m0 > u) begin r0 = m0; rH[0] = 1'b1; end
      else        begin r0 = 0;  rH[0] = 1'b0; end
    end else begin
      r0 = imax(m0, u); rH[0] = 1'b1;
      if (m1 > u) begin r1 = m1; rH[1] = 1'b1; end
      else        begin r1 = 0;  rH[1] = 1'b0; end
    end
  endfunction

  function automatic void refResolve(
      input logic [1:0] aH, input int a0, input int a1,
      input logic [1:0] bH, input int b0, input int b1, input logic [1:0] net,
      output logic [1:0] rH, output int r0, output int r1, output logic [1:0] lv);
    logic [1:0] nAH, nBH;
    int nA0, nA1, nB0, nB1, sa, sb2;
    nA0 = aH[0] ? a0 : 0; nA1 = aH[1] ? a1 : 0; nAH = aH;
    nB0 = bH[0] ? b0 : 0; nB1 = bH[1] ? b1 : 0; nBH = bH;
    if (nA0 == 0 && nA1 == 0) nAH = 2'b11;
    if (nB0 == 0 && nB1 == 0) nBH = 2'b11;
    if (nBH == 2'b11 && nB0 == 0 && nB1 == 0) begin
      rH = nAH; r0 = nA0; r1 = nA1;
    end else if (nAH == 2'b11 && nA0 == 0 && nA1 == 0) begin
      rH = nBH; r0 = nB0; r1 = nB1;
    end else if (nAH != 2'b11 && nBH != 2'b11) begin
      sa  = nAH[1] ? nA1 : nA0;
      sb2 = nBH[1] ? nB1 : nB0;
      if (sa > sb2 || (nAH == nBH && sa == sb2)) begin rH = nAH; r0 = nA0; r1 = nA1; end
      else if (sb2 > sa) begin rH = nBH; r0 = nB0; r1 = nB1; end
      else if (net == 2'b01) begin rH = 2'b01; r0 = sa; r1 = 0; end
      else if (net == 2'b10) begin rH = 2'b10; r0 = 0;  r1 = sa; end
      else begin rH = 2'b11; r0 = sa; r1 = sa; end
    end else if (nAH == 2'b11 && nBH == 2'b11) begin
      rH = 2'b11; r0 = imax(nA0, nB0); r1 = imax(nA1, nB1);
    end else if (nAH == 2'b11) begin
      mixAmb(nA0, nA1, nBH[1], nBH[1] ? nB1 : nB0, rH, r0, r1);
    end else begin
      mixAmb(nB0, nB1, nAH[1], nAH[1] ? nA1 : nA0, rH, r0, r1);
    end
    if (r0 == 0 && r1 == 0)                  lv = 2'b10;
    else if (rH == 2'b11 && r0 > 0 && r1 > 0) lv = 2'b11;
    else if (r1 > 0)                          lv = 2'b01;
    else                                      lv = 2'b00;
  endfunction

  task automatic apply(input logic [1:0] aH, input int a0, input int a1,
                       input logic [1:0] bH, input int b0, input int b1,
                       input logic [1:0] net, input string tag);
    exp_t e;
    @(posedge clk);
    {drvAHas1, drvAHas0} = aH; drvAStr0 = a0[2:0]; drvAStr1 = a1[2:0];
    {drvBHas1, drvBHas0} = bH; drvBStr0 = b0[2:0]; drvBStr1 = b1[2:0];
    netSel = net;
    refResolve(aH, a0, a1, bH, b0, b1, net, e.h, e.s0, e.s1, e.lv);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare one expected item per falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if ({resHas1, resHas0} !== e.h || int'(resStr0) != e.s0 ||
          int'(resStr1) != e.s1 || resLogic !== e.lv) begin
        fails++;
        $display("FAIL %s: got has=%b s0=%0d s1=%0d lv=%b expected has=%b s0=%0d s1=%0d lv=%b",
                 e.tag, {resHas1, resHas0}, resStr0, resStr1, resLogic,
                 e.h, e.s0, e.s1, e.lv);
      end
    end
  end

  initial begin
    // R2: idle state, no flags -> z
    apply(2'b00, 0, 0, 2'b00, 0, 0, 2'b00, "R2");
    // R2: single-flag strength-0 drivers become z
    apply(2'b01, 0, 5, 2'b10, 3, 0, 2'b00, "R2");
    // R1: garbage in absent field is ignored, absent output field is 0
    apply(2'b01, 5, 6, 2'b10, 7, 3, 2'b00, "R1");
    apply(2'b10, 4, 2, 2'b10, 1, 6, 2'b01, "R1");

    // R3..R7, R13: every ordered pair of single-point drivers, every net code
    for (int va = 0; va < 2; va++)
      for (int sa = 0; sa < 8; sa++)
        for (int vb = 0; vb < 2; vb++)
          for (int sbv = 0; sbv < 8; sbv++)
            for (int n = 0; n < 4; n++) begin
              string t;
              if (sa == 0 || sbv == 0) t = "R13";
              else if (sa != sbv)      t = "R3";
              else if (va == vb)       t = "R4";
              else if (n == 1)         t = "R6";
              else if (n == 2)         t = "R7";
              else                     t = "R5";
              apply(va ? 2'b10 : 2'b01, sa, sa, vb ? 2'b10 : 2'b01, sbv, sbv, n[1:0], t);
            end

    // R8/R9/R10: ambiguous against single point, both input positions
    for (int m0 = 1; m0 < 8; m0++)
      for (int m1 = 1; m1 < 8; m1++)
        for (int v = 0; v < 2; v++)
          for (int u = 1; u < 8; u++) begin
            int mo;
            string t;
            mo = v ? m0 : m1;
            t  = (mo > u) ? "R8" : "R9";
            apply(2'b11, m0, m1, v ? 2'b10 : 2'b01, u, u, 2'b00, t);
            apply(v ? 2'b10 : 2'b01, u, u, 2'b11, m0, m1, 2'b01, t);
          end
    // R10: value side taken from the stronger of u and the ambiguous side
    apply(2'b11, 2, 6, 2'b01, 5, 0, 2'b00, "R10");
    apply(2'b11, 7, 6, 2'b01, 5, 0, 2'b00, "R10");
    apply(2'b10, 0, 3, 2'b11, 6, 1, 2'b10, "R10");
    apply(2'b10, 0, 3, 2'b11, 6, 7, 2'b10, "R10");

    // R11: two ambiguous drivers, net code varied
    begin
      int lv3 [3] = '{0, 2, 7};
      int k = 0;
      for (int i0 = 0; i0 < 3; i0++)
        for (int i1 = 0; i1 < 3; i1++)
          for (int j0 = 0; j0 < 3; j0++)
            for (int j1 = 0; j1 < 3; j1++) begin
              string t;
              t = ((lv3[i0] == 0 && lv3[i1] == 0) || (lv3[j0] == 0 && lv3[j1] == 0)) ? "R13" : "R11";
              apply(2'b11, lv3[i0], lv3[i1], 2'b11, lv3[j0], lv3[j1], k[1:0], t);
              k++;
            end
    end

    // R12: logic code for one-sided ranges and x
    apply(2'b11, 5, 0, 2'b00, 0, 0, 2'b00, "R12");
    apply(2'b11, 0, 4, 2'b00, 0, 0, 2'b00, "R12");
    apply(2'b11, 3, 3, 2'b00, 0, 0, 2'b00, "R12");
    apply(2'b01, 6, 0, 2'b11, 0, 0, 2'b00, "R12");

    // R14: explicit swapped pairs
    apply(2'b11, 6, 2, 2'b10, 4, 4, 2'b00, "R14");
    apply(2'b10, 4, 4, 2'b11, 6, 2, 2'b00, "R14");
    apply(2'b01, 3, 0, 2'b10, 0, 3, 2'b01, "R14");
    apply(2'b10, 0, 3, 2'b01, 3, 0, 2'b01, "R14");

    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule